// File: doc/BRIEF.md
# Staggered Output Turn-On Sequencer

This block sits between the latched pattern of a 24-channel LED sink driver and its current outputs. The channels form eight columns, and each column holds the red, green and blue channel that share one index. When the active-low output enable falls, the block can release the columns one after another. This spreads the switch-on current over time and keeps the supply from seeing a single large step.

An active-low stagger select chooses the mode. It is read in the cycle where the enable fall is seen. When it is low, column 0 turns on at once and each higher column follows one step later. A step is a parameterised number of clock cycles. When it is high, all columns turn on together. Turn-off is never delayed. If the enable rises in the middle of a ramp, the columns still waiting are dropped, and the next fall starts the ramp again from column 0.

Top module: `stagger_turnon`

## Requirements
- R1: During reset `drive` is all zero. The enable is taken as high at reset, so an `oe_n` that is low when reset ends counts as a fall at the first edge after reset.
- R2: Bit `c*NCOL+k` of `data_in` and of `drive` belongs to colour c (0 red, 1 green, 2 blue) and to column k. A drive bit is high only when its data bit is high and its column has been released.
- R3: With `stagger_n` low at the fall, only column 0 is released at the first clock edge that samples `oe_n` low.
- R4: In a staggered ramp, column k is released exactly k*STEP_CYC edges after column 0. The released columns always form a contiguous run that starts at column 0, and the run grows by at most one column per edge.
- R5: The three colours of a column are released on the same edge.
- R6: With `stagger_n` high at the fall, all columns are released at the first edge that samples `oe_n` low.
- R7: At the first edge that samples `oe_n` high, every column is switched off at once.
- R8: If `oe_n` rises before the ramp completes, the pending columns are cancelled. The next fall restarts the ramp from column 0.
- R9: `stagger_n` is read only at the fall. Changing it during a ramp does not change the release timing.
- R10: Once a column is released, its drive bits follow `data_in` combinationally for as long as the enable stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| oe_n | input | 1 | Output enable, active low |
| stagger_n | input | 1 | Low selects staggered turn-on; read at the enable fall |
| data_in | input | 3*NCOL | Latched channel pattern, colour-major layout |
| drive | output | 3*NCOL | Gated channel drive to the current sinks |

## Verification
A column mask that has lost its contiguous shape, or a step counter that starts at the wrong value, shows on `drive` within one step. A column then turns on an edge early or late, or comes on out of order. A ramp that is not cancelled on disable shows as a lit channel on the edge after `oe_n` is sampled high. A stagger select that is re-read during the ramp collapses the ramp into one edge. The bench checks `drive` on every edge of every ramp, so any of these faults is caught in the cycle where it first appears.

// File: rtl/stagger_pkg.sv
package stagger_pkg;

    // Number of colour channels sharing one column index
    localparam int COLORS = 3;

    // Sequencer phase
    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_RAMP = 2'd1,
        PH_ON   = 2'd2
    } phase_e;

    // Control handed from the sequencer to the step timer
    typedef struct packed {
        logic restart;
        logic run;
    } step_ctl_t;

endpackage

// File: rtl/stagger_tick.sv
module stagger_tick
    import stagger_pkg::*;
#(
    parameter int STEP_CYC = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  step_ctl_t ctl,
    output logic      tick
);
    localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || ctl.restart) begin
            cnt <= '0;
        end else if (ctl.run) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assign tick = ctl.run && (cnt == LAST);

    // R4: the step count never leaves its range
    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R4: a new ramp always starts counting from zero
    p_restart_zero_r4: assert property (@(posedge clk) disable iff (rst)
        ctl.restart |=> cnt == '0);

endmodule

// File: rtl/stagger_seq.sv
module stagger_seq
    import stagger_pkg::*;
#(
    parameter int NCOL = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            oe_n,
    input  logic            stagger_n,
    input  logic            tick,
    output step_ctl_t       ctl,
    output logic [NCOL-1:0] col_en
);
    logic            oe_q;
    phase_e          ph;
    logic            fall;
    logic [NCOL-1:0] col_nxt;

    assign fall = oe_q && !oe_n;

    always_comb begin
        col_nxt = (col_en << 1) | NCOL'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q   <= 1'b1;
            ph     <= PH_OFF;
            col_en <= '0;
        end else begin
            oe_q <= oe_n;
            if (oe_n) begin
                ph     <= PH_OFF;
                col_en <= '0;
            end else if (fall) begin
                if (stagger_n) begin
                    col_en <= '1;
                    ph     <= PH_ON;
                end else begin
                    col_en <= NCOL'(1);
                    ph     <= (NCOL == 1) ? PH_ON : PH_RAMP;
                end
            end else if (ph == PH_RAMP && tick) begin
                col_en <= col_nxt;
                if (&col_nxt) ph <= PH_ON;
            end
        end
    end

    assign ctl.restart = fall;
    assign ctl.run     = (ph == PH_RAMP);

    // R7: a disable sampled at one edge leaves every column dark
    p_off_after_disable_r7: assert property (@(posedge clk) disable iff (rst)
        $past(oe_n) |-> col_en == '0);

    // R4: released columns are a contiguous run from column 0
    p_contiguous_r4: assert property (@(posedge clk) disable iff (rst)
        (col_en & (col_en + 1'b1)) == '0);

    // R4: a ramp adds at most one column per edge
    p_one_per_edge_r4: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_RAMP && !oe_n) |=> $countones(col_en) <= $countones($past(col_en)) + 1);

    // R6: unstaggered fall lights all columns on the next edge
    p_all_at_once_r6: assert property (@(posedge clk) disable iff (rst)
        (fall && stagger_n) |=> &col_en);

    // R3: staggered fall lights only column 0
    p_first_column_r3: assert property (@(posedge clk) disable iff (rst)
        (fall && !stagger_n) |=> col_en == NCOL'(1));

endmodule

// File: rtl/stagger_gate.sv
module stagger_gate
    import stagger_pkg::*;
#(
    parameter int NCOL = 8
) (
    input  logic [NCOL-1:0]        col_en,
    input  logic [COLORS*NCOL-1:0] data_in,
    output logic [COLORS*NCOL-1:0] drive
);
    for (genvar c = 0; c < COLORS; c++) begin : g_color
        for (genvar k = 0; k < NCOL; k++) begin : g_col
            assign drive[c*NCOL + k] = data_in[c*NCOL + k] & col_en[k];
        end
    end
endmodule

// File: rtl/stagger_turnon.sv
module stagger_turnon
    import stagger_pkg::*;
#(
    parameter int NCOL     = 8,
    parameter int STEP_CYC = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   oe_n,
    input  logic                   stagger_n,
    input  logic [COLORS*NCOL-1:0] data_in,
    output logic [COLORS*NCOL-1:0] drive
);
    step_ctl_t       ctl;
    logic            tick;
    logic [NCOL-1:0] col_en;

    stagger_seq #(.NCOL(NCOL)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .oe_n      (oe_n),
        .stagger_n (stagger_n),
        .tick      (tick),
        .ctl       (ctl),
        .col_en    (col_en)
    );

    stagger_tick #(.STEP_CYC(STEP_CYC)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ctl),
        .tick (tick)
    );

    stagger_gate #(.NCOL(NCOL)) u_gate (
        .col_en  (col_en),
        .data_in (data_in),
        .drive   (drive)
    );

    // R7: outputs are dark one edge after the enable is sampled high
    p_dark_after_disable_r7: assert property (@(posedge clk) disable iff (rst)
        $past(oe_n) |-> drive == '0);

    // R2: no channel is driven while its data bit is low
    p_no_drive_without_data_r2: assert property (@(posedge clk) disable iff (rst)
        (drive & ~data_in) == '0);

endmodule

// File: tb/sim_stagger_turnon.sv
module sim_stagger_turnon;
    localparam int NCOL = 8;
    localparam int STEP = 4;
    localparam int NB   = 3 * NCOL;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          oe_n = 1'b1;
    logic          stagger_n = 1'b0;
    logic [NB-1:0] data_in = '0;
    logic [NB-1:0] drive;

    int checks = 0;
    int errors = 0;

    stagger_turnon #(.NCOL(NCOL), .STEP_CYC(STEP)) u0 (
        .clk       (clk),
        .rst       (rst),
        .oe_n      (oe_n),
        .stagger_n (stagger_n),
        .data_in   (data_in),
        .drive     (drive)
    );

    always #4 clk = ~clk;

    // Expected drive: data masked to the first ncols columns of every colour
    function automatic logic [NB-1:0] expect_drive(input logic [NB-1:0] d, input int ncols);
        logic [NB-1:0] r = '0;
        for (int c = 0; c < 3; c++)
            for (int k = 0; k < NCOL; k++)
                if (k < ncols) r[c*NCOL + k] = d[c*NCOL + k];
        return r;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [NB-1:0] got, input logic [NB-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: drive=%h expected=%h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; oe_n = 1'b0; stagger_n = 1'b0; data_in = '1;
        step(); step();
        chk("R1 reset dark", drive, '0);
        rst = 1'b0;
        step();
        chk("R1 low enable after reset acts as fall", drive, expect_drive('1, 1));
        oe_n = 1'b1;
        step();
        chk("R7 off after reset ramp", drive, '0);
    endtask

    // R3 R4 R5 R2: full staggered ramp checked on every edge
    task automatic t_ramp(input logic [NB-1:0] pat);
        data_in = pat; stagger_n = 1'b0; oe_n = 1'b1;
        step();
        chk("R7 idle dark", drive, '0);
        oe_n = 1'b0;
        step();
        for (int m = 0; m < NCOL*STEP + 2; m++) begin
            int n = m / STEP + 1;
            if (n > NCOL) n = NCOL;
            chk("R4 R5 staggered ramp", drive, expect_drive(pat, n));
            step();
        end
        oe_n = 1'b1;
        step();
        chk("R7 immediate turn-off", drive, '0);
    endtask

    task automatic t_all_at_once();
        data_in = 24'hC3_5A_F0; stagger_n = 1'b1; oe_n = 1'b0;
        step();
        chk("R6 all columns at first edge", drive, 24'hC3_5A_F0);
        step();
        chk("R6 all columns hold", drive, 24'hC3_5A_F0);
        oe_n = 1'b1;
        step();
        chk("R7 off after unstaggered", drive, '0);
    endtask

    task automatic t_cancel();
        data_in = '1; stagger_n = 1'b0; oe_n = 1'b0;
        step();
        for (int m = 0; m < 2*STEP + 1; m++) step();
        chk("R4 mid ramp three columns", drive, expect_drive('1, 3));
        oe_n = 1'b1;
        step();
        chk("R8 rise cancels ramp", drive, '0);
        for (int m = 0; m < 3*STEP; m++) step();
        chk("R8 no pending column appears", drive, '0);
        oe_n = 1'b0;
        step();
        chk("R8 restart from column 0", drive, expect_drive('1, 1));
        for (int m = 0; m < STEP; m++) step();
        chk("R8 restart second column", drive, expect_drive('1, 2));
        oe_n = 1'b1;
        step();
    endtask

    task automatic t_select_latched();
        data_in = '1; stagger_n = 1'b0; oe_n = 1'b0;
        step();
        stagger_n = 1'b1;
        step();
        chk("R9 select change ignored", drive, expect_drive('1, 1));
        for (int m = 0; m < STEP - 1; m++) step();
        chk("R9 ramp timing kept", drive, expect_drive('1, 2));
        oe_n = 1'b1;
        step();
        stagger_n = 1'b0;
    endtask

    task automatic t_follow();
        data_in = '1; stagger_n = 1'b1; oe_n = 1'b0;
        step();
        data_in = 24'h81_42_24; #1;
        chk("R10 follows data", drive, 24'h81_42_24);
        data_in = 24'h00_FF_00; #1;
        chk("R2 green only", drive, 24'h00_FF_00);
        data_in = 24'h01_00_80; #1;
        chk("R2 blue col0 red col7", drive, 24'h01_00_80);
        oe_n = 1'b1;
        step();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_ramp('1);
        t_ramp(24'hA5_3C_96);
        t_all_at_once();
        t_cancel();
        t_select_latched();
        t_follow();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule